// File: doc/BRIEF.md
# Serial Bus Master Frame Sequencer

This block drives one master-transmit frame onto a two-level, wired-AND serial bus on which a released line reads as 1. It first holds a start field low, then shifts out the following fields, each MSB first: a broadcast flag, the unit's own address, the target address, a control nibble, a byte count, and that many data bytes. Every field from the unit address onward is followed by an even parity bit. Every field after the unit address also gets an acknowledge slot. In that slot the master releases the line and samples the target's answer.

A host loads the header inputs and the first data byte, then issues a start write. Further data bytes arrive through a request/write handshake on the data register. The block raises a one-cycle start-stage interrupt once the unit address is through, because at that point the arbitration result is known. It raises a one-cycle end interrupt when the frame finishes or is rejected. Three sticky status flags record the outcome.

Bit timing is abstracted to slots of `CLK_DIV` clocks. `START_SLOTS` sets the start field length. With the defaults of 245 and 2 at a 6.29 MHz clock, the header up to the start-stage interrupt takes about 624 µs and one data field about 390 µs.

Top module: `sbus_frame_master`

## Requirements
- R1: A frame starts only on a clock where `go_wr`, `go_en` and `go_mreq` are all 1 while `busy` is 0. Any other start write is ignored: `busy` stays 0 and `bus_tx` stays 1.
- R2: Every bit slot lasts exactly `CLK_DIV` clocks, with `bus_tx` constant inside it. The frame opens with `START_SLOTS` slots driving 0.
- R3: After the start field, the bits leave in this order, each field MSB first: broadcast (1 bit), unit address (12), target address (12), control (4), byte count n (8), then n data bytes (8 each).
- R4: Each field from the unit address onward is followed by one parity slot. That slot carries the XOR of the field bits, so the field plus its parity holds an even number of ones. The broadcast flag has no parity.
- R5: An acknowledge slot follows the parity of the target address, the control field, the byte count and every data byte, but not the unit address. In it `bus_tx` is 1, and a sampled `bus_rx` of 0 means accepted.
- R6: `irq_start` is high for exactly the first clock of the target address field, and it occurs once per frame.
- R7: The first data byte comes from the preloaded data register. Each data field k reloads from that register at its first clock. In that clock `dreq` pulses if k < n, so a frame with n bytes issues max(n-1,0) requests and none in the final data field.
- R8: After the acknowledge of the last data byte, or of the byte count when n = 0, `busy` falls, `frame_ok` sets and `irq_end` pulses for one clock.
- R9: A `bus_rx` of 1 in any acknowledge slot ends the frame at that slot. It sets `err_nak`, pulses `irq_end`, leaves `frame_ok` at 0 and issues no further `dreq`.
- R10: If `bus_rx` differs from `bus_tx` in the broadcast slot, a unit address bit or the unit address parity, the frame stops at that slot. `arb_lost` sets and `irq_start` pulses, with no `irq_end` and no `dreq`.
- R11: `err_nak`, `arb_lost` and `frame_ok` clear when a start is accepted and otherwise hold. At most one of them is set.
- R12: While `busy` is 0, `bus_tx` is 1 (released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_wr | input | 1 | Start-control write strobe |
| go_en | input | 1 | Communication-enable bit of the start write |
| go_mreq | input | 1 | Master-request bit of the start write |
| bcast | input | 1 | Broadcast flag to send |
| unit_addr | input | ADDR_W | Own address, sent in the arbitration field |
| slave_addr | input | ADDR_W | Target address |
| ctrl_word | input | CTRL_W | Control field value |
| tel_len | input | LEN_W | Number of data bytes n |
| dr_wr | input | 1 | Data register write strobe |
| dr_wdata | input | DATA_W | Data register write value |
| bus_rx | input | 1 | Bus level read back |
| bus_tx | output | 1 | Bus level driven (1 = released) |
| busy | output | 1 | Frame in progress |
| irq_start | output | 1 | Start-stage interrupt pulse |
| irq_end | output | 1 | End-of-frame interrupt pulse |
| dreq | output | 1 | Next data byte request pulse |
| err_nak | output | 1 | Frame ended on a refused acknowledge |
| arb_lost | output | 1 | Frame ended on lost arbitration |
| frame_ok | output | 1 | Frame completed normally |

## Verification
The checker watches several rules on every clock: the released line while idle, the low start field, a stable line inside each slot, `dreq` only during a frame, `irq_end` only with `busy` low, a rising `err_nak` or `arb_lost` arriving together with its interrupt, and mutually exclusive status flags. Only the bench scenarios can show that each bit in the stream carries the right value in the right order and that the parity is correct. They also show that the number of requests matches the byte count for every length, and that a refusal at each acknowledge position and a mismatch at each arbitration bit stop the frame at exactly that slot.

// File: rtl/sbus_fm_pkg.sv
package sbus_fm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_BCAST,
        PH_MADDR,
        PH_SADDR,
        PH_CTRL,
        PH_LEN,
        PH_DATA
    } phase_e;

    typedef enum logic [1:0] {
        SL_BIT,
        SL_PAR,
        SL_ACK
    } slot_e;

    typedef struct packed {
        logic nak;
        logic lost;
        logic ok;
    } status_t;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sbus_bit_tick.sv
module sbus_bit_tick #(
    parameter int unsigned DIV = 245
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = sbus_fm_pkg::cnt_bits(DIV);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sbus_field_shift.sv
module sbus_field_shift #(
    parameter int unsigned SW  = 12,
    parameter int unsigned SLW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [SW-1:0]  load_val,
    input  logic [SLW-1:0] load_w,
    input  logic           shift,
    output logic           msb,
    output logic           last,
    output logic           par
);
    logic [SW-1:0]  sh_q;
    logic [SLW-1:0] left_q;
    logic           par_q;

    assign msb  = sh_q[SW-1];
    assign last = (left_q == SLW'(1));
    assign par  = par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
            par_q  <= 1'b0;
        end else if (load) begin
            sh_q   <= load_val << (SLW'(SW) - load_w);
            left_q <= load_w;
            par_q  <= ^load_val;
        end else if (shift) begin
            sh_q   <= sh_q << 1;
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/sbus_frame_ctrl.sv
module sbus_frame_ctrl
    import sbus_fm_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned CTRL_W      = 4,
    parameter int unsigned LEN_W       = 8,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned START_SLOTS = 2,
    parameter int unsigned SW          = 12,
    parameter int unsigned SLW         = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              go_wr,
    input  logic              go_en,
    input  logic              go_mreq,
    input  logic              bcast,
    input  logic [ADDR_W-1:0] unit_addr,
    input  logic [ADDR_W-1:0] slave_addr,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [LEN_W-1:0]  tel_len,
    input  logic [DATA_W-1:0] dr_q,
    input  logic              bus_rx,
    input  logic              sh_msb,
    input  logic              sh_last,
    input  logic              sh_par,
    output logic              sh_load,
    output logic [SW-1:0]     sh_val,
    output logic [SLW-1:0]    sh_w,
    output logic              sh_shift,
    output logic              bus_tx,
    output phase_e            phase,
    output logic              irq_start,
    output logic              irq_end,
    output logic              dreq,
    output status_t           status
);
    localparam int unsigned SCW = cnt_bits(START_SLOTS);

    phase_e            ph_q, ph_d;
    slot_e             sl_q, sl_d;
    logic [SCW-1:0]    sc_q, sc_d;
    logic [LEN_W:0]    idx_q, idx_d;
    status_t           st_q, st_d;
    logic              irs_q, irs_d, ire_q, ire_d, drq_q, drq_d;
    logic              cap;
    logic              bc_q;
    logic [ADDR_W-1:0] ua_q, sa_q;
    logic [CTRL_W-1:0] ct_q;
    logic [LEN_W-1:0]  len_q;
    logic              mism;

    assign phase     = ph_q;
    assign irq_start = irs_q;
    assign irq_end   = ire_q;
    assign dreq      = drq_q;
    assign status    = st_q;

    always_comb begin
        if (ph_q == PH_IDLE) begin
            bus_tx = 1'b1;
        end else if (ph_q == PH_START) begin
            bus_tx = 1'b0;
        end else begin
            unique case (sl_q)
                SL_BIT:  bus_tx = sh_msb;
                SL_PAR:  bus_tx = sh_par;
                default: bus_tx = 1'b1;
            endcase
        end
    end

    assign mism = (bus_rx != bus_tx);

    always_comb begin
        ph_d     = ph_q;
        sl_d     = sl_q;
        sc_d     = sc_q;
        idx_d    = idx_q;
        st_d     = st_q;
        irs_d    = 1'b0;
        ire_d    = 1'b0;
        drq_d    = 1'b0;
        cap      = 1'b0;
        sh_load  = 1'b0;
        sh_val   = '0;
        sh_w     = '0;
        sh_shift = 1'b0;
        if (ph_q == PH_IDLE) begin
            if (go_wr && go_en && go_mreq) begin
                ph_d = PH_START;
                sc_d = '0;
                st_d = '0;
                cap  = 1'b1;
            end
        end else if (tick) begin
            unique case (ph_q)
                PH_START: begin
                    if (sc_q == SCW'(START_SLOTS - 1)) begin
                        ph_d    = PH_BCAST;
                        sl_d    = SL_BIT;
                        sh_load = 1'b1;
                        sh_val  = SW'(bc_q);
                        sh_w    = SLW'(1);
                    end else begin
                        sc_d = sc_q + 1'b1;
                    end
                end
                PH_BCAST, PH_MADDR: begin
                    if (mism) begin
                        ph_d      = PH_IDLE;
                        st_d.lost = 1'b1;
                        irs_d     = 1'b1;
                    end else if (sl_q == SL_BIT && !sh_last) begin
                        sh_shift = 1'b1;
                    end else if (sl_q == SL_BIT && ph_q == PH_BCAST) begin
                        ph_d    = PH_MADDR;
                        sh_load = 1'b1;
                        sh_val  = SW'(ua_q);
                        sh_w    = SLW'(ADDR_W);
                    end else if (sl_q == SL_BIT) begin
                        sl_d = SL_PAR;
                    end else begin
                        irs_d   = 1'b1;
                        ph_d    = PH_SADDR;
                        sl_d    = SL_BIT;
                        sh_load = 1'b1;
                        sh_val  = SW'(sa_q);
                        sh_w    = SLW'(ADDR_W);
                    end
                end
                default: begin
                    unique case (sl_q)
                        SL_BIT: begin
                            if (!sh_last) sh_shift = 1'b1;
                            else          sl_d     = SL_PAR;
                        end
                        SL_PAR: sl_d = SL_ACK;
                        default: begin
                            sl_d = SL_BIT;
                            if (bus_rx) begin
                                ph_d     = PH_IDLE;
                                st_d.nak = 1'b1;
                                ire_d    = 1'b1;
                            end else if (ph_q == PH_SADDR) begin
                                ph_d    = PH_CTRL;
                                sh_load = 1'b1;
                                sh_val  = SW'(ct_q);
                                sh_w    = SLW'(CTRL_W);
                            end else if (ph_q == PH_CTRL) begin
                                ph_d    = PH_LEN;
                                sh_load = 1'b1;
                                sh_val  = SW'(len_q);
                                sh_w    = SLW'(LEN_W);
                            end else if ((ph_q == PH_LEN && len_q == '0) ||
                                         (ph_q == PH_DATA && idx_q == {1'b0, len_q})) begin
                                ph_d    = PH_IDLE;
                                st_d.ok = 1'b1;
                                ire_d   = 1'b1;
                            end else begin
                                ph_d    = PH_DATA;
                                idx_d   = (ph_q == PH_LEN) ? (LEN_W+1)'(1) : idx_q + 1'b1;
                                drq_d   = (idx_d < {1'b0, len_q});
                                sh_load = 1'b1;
                                sh_val  = SW'(dr_q);
                                sh_w    = SLW'(DATA_W);
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            sl_q  <= SL_BIT;
            sc_q  <= '0;
            idx_q <= '0;
            st_q  <= '0;
            irs_q <= 1'b0;
            ire_q <= 1'b0;
            drq_q <= 1'b0;
            bc_q  <= 1'b0;
            ua_q  <= '0;
            sa_q  <= '0;
            ct_q  <= '0;
            len_q <= '0;
        end else begin
            ph_q  <= ph_d;
            sl_q  <= sl_d;
            sc_q  <= sc_d;
            idx_q <= idx_d;
            st_q  <= st_d;
            irs_q <= irs_d;
            ire_q <= ire_d;
            drq_q <= drq_d;
            if (cap) begin
                bc_q  <= bcast;
                ua_q  <= unit_addr;
                sa_q  <= slave_addr;
                ct_q  <= ctrl_word;
                len_q <= tel_len;
            end
        end
    end
endmodule

// File: rtl/sbus_frame_master.sv
module sbus_frame_master
    import sbus_fm_pkg::*;
#(
    parameter int unsigned CLK_DIV     = 245,
    parameter int unsigned START_SLOTS = 2,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned CTRL_W      = 4,
    parameter int unsigned LEN_W       = 8,
    parameter int unsigned DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_wr,
    input  logic              go_en,
    input  logic              go_mreq,
    input  logic              bcast,
    input  logic [ADDR_W-1:0] unit_addr,
    input  logic [ADDR_W-1:0] slave_addr,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [LEN_W-1:0]  tel_len,
    input  logic              dr_wr,
    input  logic [DATA_W-1:0] dr_wdata,
    input  logic              bus_rx,
    output logic              bus_tx,
    output logic              busy,
    output logic              irq_start,
    output logic              irq_end,
    output logic              dreq,
    output logic              err_nak,
    output logic              arb_lost,
    output logic              frame_ok
);
    localparam int unsigned SW  = imax(imax(ADDR_W, CTRL_W), imax(LEN_W, DATA_W));
    localparam int unsigned SLW = $clog2(SW + 1);

    logic [DATA_W-1:0] dr_q;
    logic              tick_w;
    phase_e            ph_w;
    status_t           st_w;
    logic              sh_load, sh_shift, sh_msb, sh_last, sh_par;
    logic [SW-1:0]     sh_val;
    logic [SLW-1:0]    sh_w;
    logic              in_start_w;

    always_ff @(posedge clk) begin
        if (rst)        dr_q <= '0;
        else if (dr_wr) dr_q <= dr_wdata;
    end

    assign busy       = (ph_w != PH_IDLE);
    assign in_start_w = (ph_w == PH_START);
    assign err_nak    = st_w.nak;
    assign arb_lost   = st_w.lost;
    assign frame_ok   = st_w.ok;

    sbus_bit_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick_w)
    );

    sbus_field_shift #(.SW(SW), .SLW(SLW)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .load_val (sh_val),
        .load_w   (sh_w),
        .shift    (sh_shift),
        .msb      (sh_msb),
        .last     (sh_last),
        .par      (sh_par)
    );

    sbus_frame_ctrl #(
        .ADDR_W      (ADDR_W),
        .CTRL_W      (CTRL_W),
        .LEN_W       (LEN_W),
        .DATA_W      (DATA_W),
        .START_SLOTS (START_SLOTS),
        .SW          (SW),
        .SLW         (SLW)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_w),
        .go_wr      (go_wr),
        .go_en      (go_en),
        .go_mreq    (go_mreq),
        .bcast      (bcast),
        .unit_addr  (unit_addr),
        .slave_addr (slave_addr),
        .ctrl_word  (ctrl_word),
        .tel_len    (tel_len),
        .dr_q       (dr_q),
        .bus_rx     (bus_rx),
        .sh_msb     (sh_msb),
        .sh_last    (sh_last),
        .sh_par     (sh_par),
        .sh_load    (sh_load),
        .sh_val     (sh_val),
        .sh_w       (sh_w),
        .sh_shift   (sh_shift),
        .bus_tx     (bus_tx),
        .phase      (ph_w),
        .irq_start  (irq_start),
        .irq_end    (irq_end),
        .dreq       (dreq),
        .status     (st_w)
    );
endmodule

// File: rtl/sbus_frame_master_chk.sv
module sbus_frame_master_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic bus_tx,
    input logic tick,
    input logic in_start,
    input logic irq_start,
    input logic irq_end,
    input logic dreq,
    input logic err_nak,
    input logic arb_lost,
    input logic frame_ok
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> bus_tx); // R12

    AST_START_FIELD_LOW: assert property (@(posedge clk) disable iff (rst)
        in_start |-> !bus_tx); // R2

    AST_SLOT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(tick)) |-> $stable(bus_tx)); // R2

    AST_DREQ_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        dreq |-> (busy && !arb_lost && !err_nak)); // R7

    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        irq_end |-> !busy); // R8

    AST_NAK_STOPS: assert property (@(posedge clk) disable iff (rst)
        $rose(err_nak) |-> (irq_end && !busy)); // R9

    AST_LOST_STOPS: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost) |-> (irq_start && !busy && !irq_end)); // R10

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $countones({err_nak, arb_lost, frame_ok}) <= 1); // R11
endmodule

bind sbus_frame_master sbus_frame_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .bus_tx    (bus_tx),
    .tick      (tick_w),
    .in_start  (in_start_w),
    .irq_start (irq_start),
    .irq_end   (irq_end),
    .dreq      (dreq),
    .err_nak   (err_nak),
    .arb_lost  (arb_lost),
    .frame_ok  (frame_ok)
);

// File: tb/sim_sbus_frame_master.sv
module sim_sbus_frame_master;
    localparam int DIV = 4;
    localparam int STS = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go_wr = 1'b0, go_en = 1'b0, go_mreq = 1'b0, bcast = 1'b0;
    logic [11:0] unit_addr = '0, slave_addr = '0;
    logic [3:0]  ctrl_word = '0;
    logic [7:0]  tel_len = '0;
    logic        dr_wr = 1'b0;
    logic [7:0]  dr_wdata = '0;
    logic        bus_rx = 1'b1;
    logic        bus_tx, busy, irq_start, irq_end, dreq, err_nak, arb_lost, frame_ok;

    always #5 clk = ~clk;

    sbus_frame_master #(.CLK_DIV(DIV), .START_SLOTS(STS)) u0 (
        .clk(clk), .rst(rst), .go_wr(go_wr), .go_en(go_en), .go_mreq(go_mreq),
        .bcast(bcast), .unit_addr(unit_addr), .slave_addr(slave_addr),
        .ctrl_word(ctrl_word), .tel_len(tel_len), .dr_wr(dr_wr), .dr_wdata(dr_wdata),
        .bus_rx(bus_rx), .bus_tx(bus_tx), .busy(busy), .irq_start(irq_start),
        .irq_end(irq_end), .dreq(dreq), .err_nak(err_nak), .arb_lost(arb_lost),
        .frame_ok(frame_ok)
    );

    int n_chk = 0, n_err = 0;
    int cnt_start = 0, cnt_end = 0, cnt_dreq = 0;
    int ack_i = 0, exp_dreq = 0;

    always @(posedge clk) begin
        if (irq_start) cnt_start++;
        if (irq_end)   cnt_end++;
        if (dreq)      cnt_dreq++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] data_of(input int s, input int i);
        return 8'((s * 37 + i * 53 + 11) & 255);
    endfunction

    task automatic slot_begin(input logic exp, input logic rx, input string req);
        @(negedge clk);
        go_wr = 1'b0;
        chk_eq(req, "bus_tx at slot start", int'(bus_tx), int'(exp));
        bus_rx = rx;
    endtask

    task automatic slot_end(input logic exp);
        @(posedge clk);
        @(negedge clk);
        dr_wr = 1'b0;
        repeat (DIV - 2) @(posedge clk);
        @(negedge clk);
        chk_eq("R2", "bus_tx at slot end", int'(bus_tx), int'(exp));
        @(posedge clk);
    endtask

    // fk: 0 target address, 1 control, 2 count, 3 data byte didx
    task automatic send_field(input logic [11:0] v, input int w, input int fk, input int didx,
                              input int n, input int nak_at, input logic [7:0] nxt,
                              output bit ended);
        logic p;
        bit   nak;
        p = ^v;
        ended = 0;
        for (int b = w - 1; b >= 0; b--) begin
            slot_begin(v[b], v[b], "R3");
            if (b == w - 1 && fk == 0)
                chk_eq("R6", "irq_start at target field", int'(irq_start), 1);
            if (b == w - 1 && fk == 3) begin
                chk_eq("R7", "dreq at data field start", int'(dreq), int'(didx < n));
                if (didx < n) begin
                    dr_wr = 1'b1;
                    dr_wdata = nxt;
                    exp_dreq++;
                end
            end
            slot_end(v[b]);
        end
        slot_begin(p, p, "R4");
        slot_end(p);
        nak = (ack_i == nak_at);
        slot_begin(1'b1, nak, "R5");
        ack_i++;
        slot_end(1'b1);
        if (nak) begin
            @(negedge clk);
            chk_eq("R9", "err_nak", int'(err_nak), 1);
            chk_eq("R9", "irq_end", int'(irq_end), 1);
            chk_eq("R9", "busy", int'(busy), 0);
            chk_eq("R9", "frame_ok", int'(frame_ok), 0);
            chk_eq("R9", "dreq count", cnt_dreq, exp_dreq);
            bus_rx = 1'b1;
            repeat (2 * DIV) @(negedge clk);
            chk_eq("R9", "no later dreq", cnt_dreq, exp_dreq);
            chk_eq("R12", "idle bus after refusal", int'(bus_tx), 1);
            ended = 1;
        end
    endtask

    task automatic run_frame(input logic bc, input logic [11:0] ua, input logic [11:0] sa,
                             input logic [3:0] ct, input logic [7:0] ln, input int seed,
                             input int nak_at, input int lose_at);
        logic [13:0] arb;
        bit ended;
        arb = {bc, ua, ^ua};
        @(negedge clk);
        dr_wr = 1'b1; dr_wdata = data_of(seed, 1);
        bcast = bc; unit_addr = ua; slave_addr = sa; ctrl_word = ct; tel_len = ln;
        @(negedge clk);
        dr_wr = 1'b0;
        go_wr = 1'b1; go_en = 1'b1; go_mreq = 1'b1;
        cnt_start = 0; cnt_end = 0; cnt_dreq = 0; ack_i = 0; exp_dreq = 0;
        @(posedge clk);
        for (int s = 0; s < STS; s++) begin
            slot_begin(1'b0, 1'b0, "R2");
            if (s == 0) begin
                chk_eq("R1", "busy after start", int'(busy), 1);
                chk_eq("R11", "flags cleared", int'({err_nak, arb_lost, frame_ok}), 0);
            end
            slot_end(1'b0);
        end
        for (int a = 0; a < 14; a++) begin
            logic b;
            b = arb[13 - a];
            slot_begin(b, (a == lose_at) ? ~b : b, (a == 13) ? "R4" : "R3");
            slot_end(b);
            if (a == lose_at) begin
                @(negedge clk);
                chk_eq("R10", "arb_lost", int'(arb_lost), 1);
                chk_eq("R10", "irq_start", int'(irq_start), 1);
                chk_eq("R10", "busy", int'(busy), 0);
                bus_rx = 1'b1;
                repeat (3 * DIV) @(negedge clk);
                chk_eq("R10", "no dreq", cnt_dreq, 0);
                chk_eq("R10", "no irq_end", cnt_end, 0);
                chk_eq("R12", "idle bus after loss", int'(bus_tx), 1);
                return;
            end
        end
        send_field(sa, 12, 0, 0, ln, nak_at, 8'h00, ended);
        if (ended) return;
        send_field({8'h00, ct}, 4, 1, 0, ln, nak_at, 8'h00, ended);
        if (ended) return;
        send_field({4'h0, ln}, 8, 2, 0, ln, nak_at, 8'h00, ended);
        if (ended) return;
        for (int i = 1; i <= int'(ln); i++) begin
            send_field({4'h0, data_of(seed, i)}, 8, 3, i, ln, nak_at, data_of(seed, i + 1), ended);
            if (ended) return;
        end
        @(negedge clk);
        chk_eq("R8", "irq_end", int'(irq_end), 1);
        chk_eq("R8", "frame_ok", int'(frame_ok), 1);
        chk_eq("R8", "busy", int'(busy), 0);
        chk_eq("R11", "err_nak", int'(err_nak), 0);
        chk_eq("R7", "dreq count", cnt_dreq, (ln > 0) ? int'(ln) - 1 : 0);
        chk_eq("R6", "irq_start count", cnt_start, 1);
        repeat (DIV) @(negedge clk);
        chk_eq("R11", "frame_ok holds", int'(frame_ok), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R12", "reset bus_tx", int'(bus_tx), 1);
        chk_eq("R11", "reset flags", int'({err_nak, arb_lost, frame_ok}), 0);
        chk_eq("R1", "reset busy", int'(busy), 0);

        // R1: incomplete start writes
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            go_wr = 1'b1;
            go_en = (k == 1);
            go_mreq = (k == 0);
            @(negedge clk);
            go_wr = (k == 2) ? 1'b0 : 1'b1;
            go_en = (k != 0);
            go_mreq = 1'b1;
            if (k != 2) begin
                go_en = (k == 1) ? 1'b1 : 1'b0;
                go_mreq = (k == 0) ? 1'b1 : 1'b0;
            end
            @(negedge clk);
            go_wr = 1'b0;
            repeat (2 * DIV) @(negedge clk);
            chk_eq("R1", "ignored start busy", int'(busy), 0);
            chk_eq("R1", "ignored start bus_tx", int'(bus_tx), 1);
            chk_eq("R1", "ignored start irq", cnt_start, 0);
        end

        // R3 R7 R8: byte count sweep
        for (int ln = 0; ln <= 5; ln++)
            run_frame(ln[0], 12'hA5C ^ 12'(ln * 291), 12'h3F0 + 12'(ln), 4'(ln + 7),
                      8'(ln), ln, -1, -1);
        run_frame(1'b1, 12'hFFF, 12'h000, 4'hF, 8'd2, 9, -1, -1);
        run_frame(1'b0, 12'h000, 12'hFFF, 4'h0, 8'd1, 10, -1, -1);

        // R9: refusal at every acknowledge position
        for (int k = 0; k < 5; k++)
            run_frame(1'b1, 12'h2D7, 12'h81E, 4'h9, 8'd2, 20 + k, k, -1);

        // R10: arbitration loss at every checked position
        for (int a = 0; a < 14; a++)
            run_frame(1'b1, 12'h6B3, 12'h145, 4'h3, 8'd3, 40 + a, -1, a);

        // R11: clean frame after a loss
        run_frame(1'b0, 12'h5A5, 12'h0C3, 4'h6, 8'd3, 77, -1, -1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule